// File: doc/BRIEF.md
# Condition Field and Overflow Flag Unit

This block keeps the flag state that an integer and floating-point core consults after its arithmetic. It holds a 32-bit condition vector made of eight independent 4-bit fields, together with a three-bit exception status word made of sticky summary overflow, current overflow and carry. It does no arithmetic. Operand values, record-form results, and raw overflow and carry indications arrive on its inputs. The block turns them into flag updates in a single registered cycle.

Several kinds of update can arrive in the same cycle. A compare request compares two operands, signed or unsigned, and writes the outcome into a field the request names. A record-form write classifies a result against zero and writes field 0 for integer results or field 1 for floating-point results. An arithmetic status strobe updates overflow and carry, but only for the forms that are enabled. A condition-bit logic operation combines any two condition bits into a third. A field move copies one whole field onto another. A dedicated clear is the only way to drop the sticky summary overflow.

Each field, from its most significant bit down, holds less-than, greater-than, equal and summary overflow. Field 0 occupies the top four bits of the vector. Condition bit index i (0 to 31) refers to vector bit 31-i, so index 4f is the less-than bit of field f.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cr_out` becomes all zeros and `xer_out` becomes 3'b000 (`xer_out` = {summary overflow, overflow, carry}).
- R2: A compare request writes field `cmp_field`, which is `cr_out[31-4f -: 4]` = {LT,GT,EQ,SO}. Exactly one of LT, GT and EQ is set. The comparison of `cmp_a` with `cmp_b` is two's-complement when `cmp_signed` is 1 and unsigned when it is 0.
- R3: A record-form write sets LT, GT or EQ from a signed comparison of `rec_value` against zero. The target is field 0 when `rec_is_fp` is 0 and field 1 when it is 1.
- R4: The SO bit of a field written by a compare or a record-form write equals the summary overflow value that `xer_out[2]` holds after the same clock edge.
- R5: `xer_out[1]` takes `arith_ov` when `arith_valid` and `arith_ov_en` are both 1. Otherwise it holds its value.
- R6: `xer_out[2]` becomes 1 whenever an enabled overflow is reported, and afterwards stays 1. Only `so_clear` lowers it. `so_clear` zeroes both `xer_out[2]` and `xer_out[1]`, and it wins over an overflow reported in the same cycle.
- R7: `xer_out[0]` takes `arith_ca` only when `arith_valid` and `arith_ca_en` are both 1. Compares, record writes, bit operations and moves never change it.
- R8: A bit operation writes condition bit `bop_dst` from bits `bop_src_a` (a) and `bop_src_b` (b) of the vector as it was before the edge. The codes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV (a equals b), 6 a AND NOT b, 7 a OR NOT b. All other bits are untouched.
- R9: A field move copies field `mv_src`, as it was before the edge, onto field `mv_dst` in one cycle.
- R10: Where writers overlap on a bit in the same cycle, the bit operation wins over the move. The move wins over the compare, and the compare wins over the record-form write.
- R11: In a cycle with no compare, record, bit operation or move request, `cr_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare request |
| cmp_signed | input | 1 | 1: signed compare, 0: unsigned |
| cmp_field | input | 3 | Field receiving the compare outcome |
| cmp_a | input | DATA_W | Left compare operand |
| cmp_b | input | DATA_W | Right compare operand |
| rec_valid | input | 1 | Record-form result write |
| rec_is_fp | input | 1 | 1: floating-point result (field 1), 0: integer (field 0) |
| rec_value | input | DATA_W | Result value, classified as signed against zero |
| arith_valid | input | 1 | Arithmetic status strobe |
| arith_ov_en | input | 1 | Overflow-enabled form |
| arith_ov | input | 1 | Raw overflow of the operation |
| arith_ca_en | input | 1 | Carry-producing form |
| arith_ca | input | 1 | Raw carry of the operation |
| so_clear | input | 1 | Dedicated clear of summary and current overflow |
| bop_valid | input | 1 | Condition-bit logic operation |
| bop_kind | input | 3 | Operation code (see R8) |
| bop_dst | input | 5 | Destination bit index |
| bop_src_a | input | 5 | First source bit index |
| bop_src_b | input | 5 | Second source bit index |
| mv_valid | input | 1 | Field move request |
| mv_dst | input | 3 | Destination field |
| mv_src | input | 3 | Source field |
| cr_out | output | 32 | Condition vector, field 0 in bits 31:28 |
| xer_out | output | 3 | {summary overflow, overflow, carry} |

## Verification
The bench sweeps compares over every field with operand pairs that split signed and unsigned order, including the most negative value. A design that mixed up the two compare kinds would set LT where GT belongs for those pairs. Every bit-operation code is exercised over all four input combinations, with source bits overlapping the destination, so a swapped complement or a read of the freshly written vector shows up. Overflow sequences check that a clean overflow-enabled operation lowers current overflow while the summary stays set, and that a record or compare written in the overflow cycle already carries the new summary value; a design that copied the old value would fail here. Collisions of all four writers on one field, and a clear arriving together with an overflow, expose a wrong priority order.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int FIELD_W     = 4;
    localparam int NUM_FIELDS  = 8;
    localparam int CR_W        = FIELD_W * NUM_FIELDS;
    localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);
    localparam int BIT_IDX_W   = $clog2(CR_W);

    typedef enum logic [2:0] {
        BOP_AND  = 3'd0,
        BOP_OR   = 3'd1,
        BOP_XOR  = 3'd2,
        BOP_NAND = 3'd3,
        BOP_NOR  = 3'd4,
        BOP_EQV  = 3'd5,
        BOP_ANDC = 3'd6,
        BOP_ORC  = 3'd7
    } bop_kind_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xer_t;

    function automatic logic apply_bop(bop_kind_e k, logic a, logic b);
        case (k)
            BOP_AND:  return a & b;
            BOP_OR:   return a | b;
            BOP_XOR:  return a ^ b;
            BOP_NAND: return ~(a & b);
            BOP_NOR:  return ~(a | b);
            BOP_EQV:  return ~(a ^ b);
            BOP_ANDC: return a & ~b;
            default:  return a | ~b;
        endcase
    endfunction
endpackage

// File: rtl/cfu_compare.sv
module cfu_compare
    import cfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    input  logic              so_in,
    output cr_field_t         result
);
    logic less;
    logic equal;

    always_comb begin
        equal = (a == b);
        if (is_signed) less = ($signed(a) < $signed(b));
        else           less = (a < b);
        result.lt = less;
        result.gt = !less && !equal;
        result.eq = equal;
        result.so = so_in;
    end
endmodule

// File: rtl/cfu_bit_logic.sv
module cfu_bit_logic
    import cfu_pkg::*;
(
    input  logic [CR_W-1:0]      cr_vec,
    input  logic [2:0]           kind,
    input  logic [BIT_IDX_W-1:0] src_a,
    input  logic [BIT_IDX_W-1:0] src_b,
    output logic                 bit_out
);
    logic [BIT_IDX_W-1:0] pos_a;
    logic [BIT_IDX_W-1:0] pos_b;

    always_comb begin
        pos_a   = BIT_IDX_W'(CR_W - 1) - src_a;
        pos_b   = BIT_IDX_W'(CR_W - 1) - src_b;
        bit_out = apply_bop(bop_kind_e'(kind), cr_vec[pos_a], cr_vec[pos_b]);
    end
endmodule

// File: rtl/cfu_status_reg.sv
module cfu_status_reg
    import cfu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arith_valid,
    input  logic arith_ov_en,
    input  logic arith_ov,
    input  logic arith_ca_en,
    input  logic arith_ca,
    input  logic so_clear,
    output xer_t status_q,
    output logic so_next
);
    xer_t status_d;

    always_comb begin
        status_d = status_q;
        if (arith_valid && arith_ca_en) status_d.ca = arith_ca;
        if (so_clear) begin
            status_d.so = 1'b0;
            status_d.ov = 1'b0;
        end else if (arith_valid && arith_ov_en) begin
            status_d.ov = arith_ov;
            status_d.so = status_q.so | arith_ov;
        end
        so_next = status_d.so;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmp_valid,
    input  logic                   cmp_signed,
    input  logic [FIELD_IDX_W-1:0] cmp_field,
    input  logic [DATA_W-1:0]      cmp_a,
    input  logic [DATA_W-1:0]      cmp_b,
    input  logic                   rec_valid,
    input  logic                   rec_is_fp,
    input  logic [DATA_W-1:0]      rec_value,
    input  logic                   arith_valid,
    input  logic                   arith_ov_en,
    input  logic                   arith_ov,
    input  logic                   arith_ca_en,
    input  logic                   arith_ca,
    input  logic                   so_clear,
    input  logic                   bop_valid,
    input  logic [2:0]             bop_kind,
    input  logic [BIT_IDX_W-1:0]   bop_dst,
    input  logic [BIT_IDX_W-1:0]   bop_src_a,
    input  logic [BIT_IDX_W-1:0]   bop_src_b,
    input  logic                   mv_valid,
    input  logic [FIELD_IDX_W-1:0] mv_dst,
    input  logic [FIELD_IDX_W-1:0] mv_src,
    output logic [CR_W-1:0]        cr_out,
    output logic [2:0]             xer_out
);
    // Packed so that field 0 lands in the most significant nibble.
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld_d;

    xer_t      status_q;
    logic      so_next;
    cr_field_t cmp_res;
    cr_field_t rec_res;
    logic      bop_bit;
    logic [FIELD_IDX_W-1:0] rec_field;
    logic [FIELD_W-1:0]     mv_nib;

    cfu_status_reg i_status (
        .clk         (clk),
        .rst         (rst),
        .arith_valid (arith_valid),
        .arith_ov_en (arith_ov_en),
        .arith_ov    (arith_ov),
        .arith_ca_en (arith_ca_en),
        .arith_ca    (arith_ca),
        .so_clear    (so_clear),
        .status_q    (status_q),
        .so_next     (so_next)
    );

    cfu_compare #(.DATA_W(DATA_W)) i_cmp (
        .a         (cmp_a),
        .b         (cmp_b),
        .is_signed (cmp_signed),
        .so_in     (so_next),
        .result    (cmp_res)
    );

    cfu_compare #(.DATA_W(DATA_W)) i_rec (
        .a         (rec_value),
        .b         ('0),
        .is_signed (1'b1),
        .so_in     (so_next),
        .result    (rec_res)
    );

    cfu_bit_logic i_bop (
        .cr_vec  (fld_q),
        .kind    (bop_kind),
        .src_a   (bop_src_a),
        .src_b   (bop_src_b),
        .bit_out (bop_bit)
    );

    always_comb begin
        rec_field = rec_is_fp ? FIELD_IDX_W'(1) : FIELD_IDX_W'(0);
        mv_nib    = fld_q[FIELD_IDX_W'(NUM_FIELDS - 1) - mv_src];
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int SLOT = NUM_FIELDS - 1 - f;
        always_comb begin
            fld_d[SLOT] = fld_q[SLOT];
            if (rec_valid && rec_field == FIELD_IDX_W'(f)) fld_d[SLOT] = rec_res;
            if (cmp_valid && cmp_field == FIELD_IDX_W'(f)) fld_d[SLOT] = cmp_res;
            if (mv_valid && mv_dst == FIELD_IDX_W'(f))     fld_d[SLOT] = mv_nib;
            for (int k = 0; k < FIELD_W; k++) begin
                if (bop_valid && bop_dst == BIT_IDX_W'(FIELD_W * f + k))
                    fld_d[SLOT][FIELD_W-1-k] = bop_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fld_q <= '0;
        else     fld_q <= fld_d;
    end

    assign cr_out  = fld_q;
    assign xer_out = status_q;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker
    import cfu_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   cmp_valid,
    input logic [FIELD_IDX_W-1:0] cmp_field,
    input logic                   rec_valid,
    input logic                   rec_is_fp,
    input logic                   arith_valid,
    input logic                   arith_ov_en,
    input logic                   arith_ov,
    input logic                   arith_ca_en,
    input logic                   so_clear,
    input logic                   bop_valid,
    input logic                   mv_valid,
    input logic [CR_W-1:0]        cr_out,
    input logic [2:0]             xer_out
);
    logic                   pend_cmp;
    logic [FIELD_IDX_W-1:0] pend_field;
    logic [FIELD_W-1:0]     pend_nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cmp   <= 1'b0;
            pend_field <= '0;
        end else begin
            pend_cmp   <= cmp_valid && !bop_valid && !mv_valid;
            pend_field <= cmp_field;
        end
    end

    assign pend_nib = cr_out[CR_W-1-FIELD_W*int'(pend_field) -: FIELD_W];

    assert_cmp_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        pend_cmp |-> ($countones(pend_nib[FIELD_W-1:1]) == 1));

    assert_rec_so_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_is_fp && !cmp_valid && !bop_valid && !mv_valid)
        |=> (cr_out[CR_W-FIELD_W] == xer_out[2]));

    assert_ov_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!(arith_valid && arith_ov_en) && !so_clear) |=> $stable(xer_out[1]));

    assert_so_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (xer_out[2] && !so_clear) |=> xer_out[2]);

    assert_so_set_R6: assert property (@(posedge clk) disable iff (rst)
        (arith_valid && arith_ov_en && arith_ov && !so_clear) |=> xer_out[2]);

    assert_so_clear_R6: assert property (@(posedge clk) disable iff (rst)
        so_clear |=> (!xer_out[2] && !xer_out[1]));

    assert_ca_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(arith_valid && arith_ca_en) |=> $stable(xer_out[0]));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !(cmp_valid || rec_valid || bop_valid || mv_valid) |=> $stable(cr_out));
endmodule

bind cond_flag_unit cfu_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmp_valid   (cmp_valid),
    .cmp_field   (cmp_field),
    .rec_valid   (rec_valid),
    .rec_is_fp   (rec_is_fp),
    .arith_valid (arith_valid),
    .arith_ov_en (arith_ov_en),
    .arith_ov    (arith_ov),
    .arith_ca_en (arith_ca_en),
    .so_clear    (so_clear),
    .bop_valid   (bop_valid),
    .mv_valid    (mv_valid),
    .cr_out      (cr_out),
    .xer_out     (xer_out)
);

// File: tb/test_cond_flag_unit.sv
`timescale 1ns/1ps
module test_cond_flag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_valid, cmp_signed;
    logic [2:0]  cmp_field;
    logic [31:0] cmp_a, cmp_b;
    logic        rec_valid, rec_is_fp;
    logic [31:0] rec_value;
    logic        arith_valid, arith_ov_en, arith_ov, arith_ca_en, arith_ca;
    logic        so_clear;
    logic        bop_valid;
    logic [2:0]  bop_kind;
    logic [4:0]  bop_dst, bop_src_a, bop_src_b;
    logic        mv_valid;
    logic [2:0]  mv_dst, mv_src;
    logic [31:0] cr_out;
    logic [2:0]  xer_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_cr;
    logic [2:0]  m_xer;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (.*);

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [31:0] next_rng(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic idle_inputs();
        cmp_valid = 0; cmp_signed = 0; cmp_field = 0; cmp_a = 0; cmp_b = 0;
        rec_valid = 0; rec_is_fp = 0; rec_value = 0;
        arith_valid = 0; arith_ov_en = 0; arith_ov = 0; arith_ca_en = 0; arith_ca = 0;
        so_clear = 0; bop_valid = 0; bop_kind = 0; bop_dst = 0; bop_src_a = 0; bop_src_b = 0;
        mv_valid = 0; mv_dst = 0; mv_src = 0;
    endtask

    function automatic logic [3:0] classify(logic lt, logic eq, logic so);
        return {lt, !lt && !eq, eq, so};
    endfunction

    // Model written from the requirements; later writers overwrite earlier ones.
    task automatic step(string tag);
        logic [31:0] e = m_cr;
        logic        so = m_xer[2], ov = m_xer[1], ca = m_xer[0];
        logic        a, b, r;
        int          f;
        if (arith_valid && arith_ca_en) ca = arith_ca;
        if (so_clear) begin so = 0; ov = 0; end
        else if (arith_valid && arith_ov_en) begin ov = arith_ov; so = so | arith_ov; end
        if (rec_valid) begin
            f = rec_is_fp ? 1 : 0;
            e[31-4*f -: 4] = classify($signed(rec_value) < 0, rec_value == 0, so);
        end
        if (cmp_valid) begin
            f = cmp_field;
            e[31-4*f -: 4] = classify(cmp_signed ? ($signed(cmp_a) < $signed(cmp_b)) : (cmp_a < cmp_b),
                                      cmp_a == cmp_b, so);
        end
        if (mv_valid) e[31-4*mv_dst -: 4] = m_cr[31-4*mv_src -: 4];
        if (bop_valid) begin
            a = m_cr[31-bop_src_a]; b = m_cr[31-bop_src_b];
            case (bop_kind)
                0: r = a & b;    1: r = a | b;     2: r = a ^ b;     3: r = !(a & b);
                4: r = !(a | b); 5: r = (a == b);  6: r = a & !b;    default: r = a | !b;
            endcase
            e[31-bop_dst] = r;
        end
        @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (cr_out !== e) begin
            n_fail++;
            $display("FAIL %s cr: actual %h expected %h", tag, cr_out, e);
        end
        n_tests++;
        if (xer_out !== {so, ov, ca}) begin
            n_fail++;
            $display("FAIL %s xer: actual %b expected %b", tag, xer_out, {so, ov, ca});
        end
        m_cr  = e;
        m_xer = {so, ov, ca};
        idle_inputs();
    endtask

    initial begin
        logic [31:0] va [5];
        logic [31:0] rv [5];
        va = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'h8000_0000};
        rv = '{32'h0, 32'h5, 32'hFFFF_FFFB, 32'h8000_0000, 32'h7FFF_FFFF};
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        n_tests++;
        if (cr_out !== 32'h0 || xer_out !== 3'b000) begin
            n_fail++;
            $display("FAIL R1 reset: actual %h/%b expected 0/000", cr_out, xer_out);
        end
        m_cr = 0; m_xer = 0;

        // R2: compare sweep over fields, kinds and operand pairs
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j += 2) begin
                        cmp_valid = 1; cmp_signed = s[0]; cmp_field = 3'(f);
                        cmp_a = va[i]; cmp_b = va[(i + j + 1) % 5];
                        step("R2");
                    end

        // R3: record-form writes, integer then floating-point target
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 5; i++) begin
                rec_valid = 1; rec_is_fp = p[0]; rec_value = rv[i];
                step("R3");
            end

        // R5, R6: overflow sequences
        arith_valid = 1; arith_ov_en = 0; arith_ov = 1; step("R5");
        arith_valid = 1; arith_ov_en = 1; arith_ov = 1; rec_valid = 1; rec_value = 32'h3; step("R4");
        arith_valid = 1; arith_ov_en = 1; arith_ov = 0; step("R5");
        arith_valid = 1; arith_ov_en = 1; arith_ov = 0; step("R6");
        cmp_valid = 1; cmp_field = 3'd5; cmp_a = 7; cmp_b = 9; step("R4");
        rec_valid = 1; rec_is_fp = 1; rec_value = 0; step("R4");
        so_clear = 1; arith_valid = 1; arith_ov_en = 1; arith_ov = 1; cmp_valid = 1; cmp_field = 3'd2;
        step("R6");
        so_clear = 1; step("R6");
        arith_valid = 1; arith_ov_en = 1; arith_ov = 1; step("R6");
        so_clear = 1; rec_valid = 1; rec_value = 32'hFFFF_FFFF; step("R4");

        // R7: carry only from carry forms
        arith_valid = 1; arith_ca_en = 1; arith_ca = 1; step("R7");
        cmp_valid = 1; cmp_a = 1; cmp_b = 2; rec_valid = 1; rec_is_fp = 1; step("R7");
        arith_valid = 1; arith_ca_en = 0; arith_ca = 0; step("R7");
        bop_valid = 1; bop_kind = 3'd3; bop_dst = 5'd9; mv_valid = 1; mv_dst = 3'd6; mv_src = 3'd0;
        step("R7");
        arith_valid = 1; arith_ca_en = 1; arith_ca = 0; step("R7");

        // R8: every code over every input combination
        for (int k = 0; k < 8; k++)
            for (int c = 0; c < 4; c++) begin
                bop_valid = 1; bop_kind = 3'(k);
                bop_dst = 5'd30; bop_src_a = 5'd28 + 5'(c[1]); bop_src_b = 5'd28 + 5'(c[0]);
                if (c == 0) begin cmp_valid = 1; cmp_field = 3'd7; cmp_a = 1; cmp_b = 2; end
                step("R8");
                bop_valid = 1; bop_kind = 3'(k); bop_dst = 5'(c * 8 + k);
                bop_src_a = 5'(c * 8 + k); bop_src_b = 5'(31 - c * 8 - k);
                step("R8");
            end
        // R8: pseudo-random bit operations mixed with compares
        for (int i = 0; i < 300; i++) begin
            rng = next_rng(rng);
            bop_valid = 1; bop_kind = rng[2:0]; bop_dst = rng[7:3];
            bop_src_a = rng[12:8]; bop_src_b = rng[17:13];
            if (rng[18]) begin
                cmp_valid = 1; cmp_signed = rng[19]; cmp_field = rng[22:20];
                cmp_a = {28'h0, rng[26:23]}; cmp_b = {28'h0, rng[30:27]};
            end
            step("R8");
        end

        // R9: all move pairs, including self
        for (int d = 0; d < 8; d++)
            for (int s = 0; s < 8; s++) begin
                mv_valid = 1; mv_dst = 3'(d); mv_src = 3'(s);
                step("R9");
                rng = next_rng(rng);
                cmp_valid = 1; cmp_signed = rng[0]; cmp_field = 3'(s);
                cmp_a = rng; cmp_b = next_rng(rng);
                step("R9");
            end

        // R10: overlapping writers
        for (int i = 0; i < 16; i++) begin
            rng = next_rng(rng);
            rec_valid = 1; rec_is_fp = rng[0]; rec_value = rng;
            cmp_valid = rng[1]; cmp_field = {2'b00, rng[2]}; cmp_a = 3; cmp_b = {30'h0, rng[4:3]};
            mv_valid = rng[5]; mv_dst = {2'b00, rng[6]}; mv_src = rng[9:7];
            bop_valid = rng[10]; bop_kind = rng[13:11]; bop_dst = {2'b00, rng[16:14]};
            bop_src_a = rng[21:17]; bop_src_b = 5'd4;
            step("R10");
        end

        // R11: idle cycles and status-only cycles leave the vector alone
        step("R11");
        arith_valid = 1; arith_ov_en = 1; arith_ov = 1; arith_ca_en = 1; arith_ca = 1; step("R11");
        so_clear = 1; step("R11");
        step("R11");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule